// File: doc/BRIEF.md
# Overlapping Register Window File

This block is a windowed integer register file for a processor core. Each procedure level gets its own window of registers. The windows sit in a circular buffer of physical storage. The outgoing (temporary) group of one window is the same storage as the incoming (parameter) group of the next deeper window, so a caller passes arguments to a callee without copying them. A small group of global registers stays visible from every window.

Two read ports and one write port take a window-relative register number. The block translates that number into a physical location using the current window pointer. A call strobe moves the current window pointer one step deeper, and a return strobe moves it one step back. A saved window pointer marks the oldest window still held in the file.

When a call would run into that oldest window, the block raises an overflow trap request instead of moving. When a return would go past it, the block raises an underflow trap request. The trap software moves windows between the file and memory. It then reports a completed spill or fill on dedicated strobes, and those strobes move the saved pointer.

Top module: `rwin_regfile`

## Requirements
- R1: After synchronous reset, the current and saved window pointers are both 0 and neither trap request is asserted.
- R2: A 5-bit register number splits into an area in bits [4:3] and an offset in bits [2:0]. Area 0 selects the globals, area 1 the parameter group, area 2 the local group and area 3 the temporary group of the current window.
- R3: A global register holds the same value whichever window is current, and a write to a global from any window is seen from every other window.
- R4: Temporary register k of window w is the same storage as parameter register k of window w+1. Local registers of one window are never seen from another window.
- R5: A call that raises no trap advances the current window pointer by one, modulo the window count, at the next clock edge.
- R6: A return that raises no trap moves the current window pointer back by one, modulo the window count.
- R7: A call when (current + 2) mod windows equals the saved pointer leaves the current pointer unchanged and raises the overflow request for exactly one cycle.
- R8: A return when the current pointer equals the saved pointer leaves the current pointer unchanged and raises the underflow request for exactly one cycle.
- R9: A spill-done strobe advances the saved pointer by one and a fill-done strobe moves it back by one, both modulo the window count. The two strobes together leave it unchanged.
- R10: Call and return asserted in the same cycle are ignored: no pointer moves and no trap is raised.
- R11: Reads are combinational. A write takes effect at the clock edge, so a read of the same register during the write cycle returns the old value and a read after the edge returns the new one, also through the overlapping alias.
- R12: The window buffer wraps. The temporary group of the last window is the parameter group of window 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_i | input | 1 | Procedure call strobe |
| ret_i | input | 1 | Procedure return strobe |
| spill_done_i | input | 1 | Trap software has saved the oldest window |
| fill_done_i | input | 1 | Trap software has restored a window |
| rd_a_idx_i | input | 5 | Read port A register number |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_idx_i | input | 5 | Read port B register number |
| rd_b_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | Write enable |
| wr_idx_i | input | 5 | Write register number |
| wr_data_i | input | 32 | Write data |
| cwp_o | output | 3 | Current window pointer |
| swp_o | output | 3 | Saved window pointer |
| ovf_trap_o | output | 1 | Window overflow trap request |
| unf_trap_o | output | 1 | Window underflow trap request |

## Verification
The assertions check the pointer rules on every cycle: a call or a return steps the current pointer, a trap freezes it and pulses its request, colliding strobes have no effect, and the saved pointer stays still without a spill or fill. Whether data lands in the right physical register cannot be seen from the pointer logic. That part is shown only by the bench's scenarios: a sweep through every window that writes locals and temporaries and reads all 32 register numbers on both ports, the wrap from the last window back to window 0, and a write-then-read through the alias across a call.

// File: rtl/rwin_pkg.sv
`timescale 1ns/1ps
package rwin_pkg;
  // register-number area field, bits [top:top-1] of a register number
  typedef enum logic [1:0] {
    AREA_GLOB = 2'd0,
    AREA_IN   = 2'd1,
    AREA_LOC  = 2'd2,
    AREA_OUT  = 2'd3
  } area_e;
endpackage

// File: rtl/rwin_xlate.sv
`timescale 1ns/1ps
// Window-relative register number -> physical location (R2, R4, R12)
module rwin_xlate
  import rwin_pkg::*;
#(
  parameter int NWIN   = 8,
  parameter int GRP    = 8,
  parameter int PTR_W  = $clog2(NWIN),
  parameter int GRP_W  = $clog2(GRP),
  parameter int IDX_W  = GRP_W + 2,
  parameter int PHYS_W = $clog2(NWIN * 2 * GRP)
) (
  input  logic [PTR_W-1:0]  cwp_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              is_glob_o,
  output logic [PHYS_W-1:0] win_addr_o,
  output logic [GRP_W-1:0]  glob_addr_o
);
  localparam int WIN_SPAN = 2 * GRP;  // private storage per window

  area_e             area;
  logic [GRP_W-1:0]  off;
  logic [PTR_W-1:0]  nxt_win;
  logic [PTR_W-1:0]  sel_win;

  always_comb begin
    area        = area_e'(idx_i[IDX_W-1 -: 2]);
    off         = idx_i[GRP_W-1:0];
    // the deeper neighbour, wrapping at the end of the buffer
    nxt_win     = (cwp_i == PTR_W'(NWIN - 1)) ? '0 : cwp_i + PTR_W'(1);
    // outgoing group lives in the next window's incoming slot
    sel_win     = (area == AREA_OUT) ? nxt_win : cwp_i;
    is_glob_o   = (area == AREA_GLOB);
    glob_addr_o = off;
    win_addr_o  = PHYS_W'(sel_win) * PHYS_W'(WIN_SPAN)
                + ((area == AREA_LOC) ? PHYS_W'(GRP) : '0)
                + PHYS_W'(off);
  end
endmodule

// File: rtl/rwin_ptr.sv
`timescale 1ns/1ps
// Current / saved window pointers and trap detection (R1, R5-R10)
module rwin_ptr #(
  parameter int NWIN  = 8,
  parameter int PTR_W = $clog2(NWIN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             call_i,
  input  logic             ret_i,
  input  logic             spill_i,
  input  logic             fill_i,
  output logic [PTR_W-1:0] cwp_o,
  output logic [PTR_W-1:0] swp_o,
  output logic             ovf_o,
  output logic             unf_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NWIN - 1);

  function automatic logic [PTR_W-1:0] step_up(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + PTR_W'(1);
  endfunction

  function automatic logic [PTR_W-1:0] step_down(input logic [PTR_W-1:0] p);
    return (p == '0) ? LAST : p - PTR_W'(1);
  endfunction

  logic [PTR_W-1:0] cwp_q, swp_q;
  logic             ovf_q, unf_q;
  logic             do_call, do_ret, full, empty;
  logic             do_spill, do_fill;

  always_comb begin
    do_call  = call_i & ~ret_i;
    do_ret   = ret_i & ~call_i;
    do_spill = spill_i & ~fill_i;
    do_fill  = fill_i & ~spill_i;
    // a new window's outgoing group would land on the oldest held window
    full     = (step_up(step_up(cwp_q)) == swp_q);
    empty    = (cwp_q == swp_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cwp_q <= '0;
      swp_q <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      ovf_q <= do_call & full;
      unf_q <= do_ret & empty;
      if (do_call && !full)      cwp_q <= step_up(cwp_q);
      else if (do_ret && !empty) cwp_q <= step_down(cwp_q);
      if (do_spill)              swp_q <= step_up(swp_q);
      else if (do_fill)          swp_q <= step_down(swp_q);
    end
  end

  assign cwp_o = cwp_q;
  assign swp_o = swp_q;
  assign ovf_o = ovf_q;
  assign unf_o = unf_q;

  // R5: an accepted call lands one window deeper
  a_r5_call_steps: assert property (@(posedge clk) disable iff (rst)
    (call_i && !ret_i && !full) |=> (cwp_q == step_up($past(cwp_q))));

  // R6: an accepted return lands one window shallower
  a_r6_ret_steps: assert property (@(posedge clk) disable iff (rst)
    (ret_i && !call_i && cwp_q != swp_q) |=> (cwp_q == step_down($past(cwp_q))));

  // R7: overflow freezes the pointer and requests a trap
  a_r7_no_overflow_move: assert property (@(posedge clk) disable iff (rst)
    (call_i && !ret_i && full) |=> (ovf_q && $stable(cwp_q)));

  // R8: underflow freezes the pointer and requests a trap
  a_r8_no_underflow_move: assert property (@(posedge clk) disable iff (rst)
    (ret_i && !call_i && cwp_q == swp_q) |=> (unf_q && $stable(cwp_q)));

  // R9: saved pointer only moves on a spill or fill report
  a_r9_swp_quiet: assert property (@(posedge clk) disable iff (rst)
    (!spill_i && !fill_i) |=> $stable(swp_q));

  // R10: colliding call and return do nothing
  a_r10_collide_ignored: assert property (@(posedge clk) disable iff (rst)
    (call_i && ret_i) |=> ($stable(cwp_q) && !ovf_q && !unf_q));

  // R7/R8: the two requests never coincide
  a_r7_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(ovf_q && unf_q));
endmodule

// File: rtl/rwin_store.sv
`timescale 1ns/1ps
// Window storage and global storage: one write port, NRD read ports (R3, R11)
module rwin_store #(
  parameter int DATA_W = 32,
  parameter int PHYS   = 128,
  parameter int GRP    = 8,
  parameter int NRD    = 2,
  parameter int PHYS_W = $clog2(PHYS),
  parameter int GRP_W  = $clog2(GRP)
) (
  input  logic                       clk,
  input  logic                       wr_en_i,
  input  logic                       wr_glob_i,
  input  logic [PHYS_W-1:0]          wr_waddr_i,
  input  logic [GRP_W-1:0]           wr_gaddr_i,
  input  logic [DATA_W-1:0]          wr_data_i,
  input  logic [NRD-1:0]             rd_glob_i,
  input  logic [NRD-1:0][PHYS_W-1:0] rd_waddr_i,
  input  logic [NRD-1:0][GRP_W-1:0]  rd_gaddr_i,
  output logic [NRD-1:0][DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] win_mem  [PHYS];
  logic [DATA_W-1:0] glob_mem [GRP];

  // plain write-only processes so the arrays map onto distributed RAM
  always_ff @(posedge clk) begin
    if (wr_en_i && !wr_glob_i) win_mem[wr_waddr_i] <= wr_data_i;
  end

  always_ff @(posedge clk) begin
    if (wr_en_i && wr_glob_i) glob_mem[wr_gaddr_i] <= wr_data_i;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_data_o[p] = rd_glob_i[p] ? glob_mem[rd_gaddr_i[p]]
                                       : win_mem[rd_waddr_i[p]];
  end
endmodule

// File: rtl/rwin_regfile.sv
`timescale 1ns/1ps
// Overlapping register window file, top level
module rwin_regfile #(
  parameter int NWIN   = 8,
  parameter int GRP    = 8,
  parameter int DATA_W = 32,
  parameter int PTR_W  = $clog2(NWIN),
  parameter int IDX_W  = $clog2(GRP) + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              call_i,
  input  logic              ret_i,
  input  logic              spill_done_i,
  input  logic              fill_done_i,
  input  logic [IDX_W-1:0]  rd_a_idx_i,
  output logic [DATA_W-1:0] rd_a_data_o,
  input  logic [IDX_W-1:0]  rd_b_idx_i,
  output logic [DATA_W-1:0] rd_b_data_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [PTR_W-1:0]  cwp_o,
  output logic [PTR_W-1:0]  swp_o,
  output logic              ovf_trap_o,
  output logic              unf_trap_o
);
  localparam int GRP_W  = $clog2(GRP);
  localparam int PHYS   = NWIN * 2 * GRP;
  localparam int PHYS_W = $clog2(PHYS);
  localparam int NPORT  = 3;   // two reads, one write
  localparam int WR_P   = 2;

  logic [PTR_W-1:0]             cwp;
  logic [NPORT-1:0][IDX_W-1:0]  idx_all;
  logic [NPORT-1:0]             glob_all;
  logic [NPORT-1:0][PHYS_W-1:0] waddr_all;
  logic [NPORT-1:0][GRP_W-1:0]  gaddr_all;
  logic [1:0][DATA_W-1:0]       rd_data;

  rwin_ptr #(.NWIN(NWIN), .PTR_W(PTR_W)) ptr_i (
    .clk     (clk),
    .rst     (rst),
    .call_i  (call_i),
    .ret_i   (ret_i),
    .spill_i (spill_done_i),
    .fill_i  (fill_done_i),
    .cwp_o   (cwp),
    .swp_o   (swp_o),
    .ovf_o   (ovf_trap_o),
    .unf_o   (unf_trap_o)
  );

  assign cwp_o   = cwp;
  assign idx_all = {wr_idx_i, rd_b_idx_i, rd_a_idx_i};

  for (genvar p = 0; p < NPORT; p++) begin : g_xl
    rwin_xlate #(
      .NWIN(NWIN), .GRP(GRP), .PTR_W(PTR_W),
      .GRP_W(GRP_W), .IDX_W(IDX_W), .PHYS_W(PHYS_W)
    ) xl_i (
      .cwp_i       (cwp),
      .idx_i       (idx_all[p]),
      .is_glob_o   (glob_all[p]),
      .win_addr_o  (waddr_all[p]),
      .glob_addr_o (gaddr_all[p])
    );
  end

  rwin_store #(
    .DATA_W(DATA_W), .PHYS(PHYS), .GRP(GRP), .NRD(2),
    .PHYS_W(PHYS_W), .GRP_W(GRP_W)
  ) store_i (
    .clk        (clk),
    .wr_en_i    (wr_en_i),
    .wr_glob_i  (glob_all[WR_P]),
    .wr_waddr_i (waddr_all[WR_P]),
    .wr_gaddr_i (gaddr_all[WR_P]),
    .wr_data_i  (wr_data_i),
    .rd_glob_i  (glob_all[1:0]),
    .rd_waddr_i (waddr_all[1:0]),
    .rd_gaddr_i (gaddr_all[1:0]),
    .rd_data_o  (rd_data)
  );

  assign rd_a_data_o = rd_data[0];
  assign rd_b_data_o = rd_data[1];
endmodule

// File: tb/rwin_regfile_tb.sv
`timescale 1ns/1ps
module rwin_regfile_tb_top;
  localparam int NWIN  = 8;
  localparam int GRP   = 8;
  localparam int NIDX  = 4 * GRP;
  localparam int NPHYS = NWIN * 2 * GRP;

  logic clk = 1'b0;
  logic rst;
  logic call_i, ret_i, spill_done_i, fill_done_i;
  logic [4:0]  rd_a_idx_i, rd_b_idx_i, wr_idx_i;
  logic [31:0] rd_a_data_o, rd_b_data_o, wr_data_i;
  logic        wr_en_i;
  logic [2:0]  cwp_o, swp_o;
  logic        ovf_trap_o, unf_trap_o;

  always #2.5 clk = ~clk;

  rwin_regfile dut_i (
    .clk(clk), .rst(rst), .call_i(call_i), .ret_i(ret_i),
    .spill_done_i(spill_done_i), .fill_done_i(fill_done_i),
    .rd_a_idx_i(rd_a_idx_i), .rd_a_data_o(rd_a_data_o),
    .rd_b_idx_i(rd_b_idx_i), .rd_b_data_o(rd_b_data_o),
    .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i),
    .cwp_o(cwp_o), .swp_o(swp_o),
    .ovf_trap_o(ovf_trap_o), .unf_trap_o(unf_trap_o)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  logic [31:0] m_win  [NPHYS];
  logic [31:0] m_glob [GRP];
  int m_cwp = 0;
  int m_swp = 0;

  function automatic logic [31:0] loc_val(int w, int k);
    return 32'h4C00_0000 | (w << 8) | k;
  endfunction
  function automatic logic [31:0] tmp_val(int w, int k);
    return 32'h7E00_0000 | (w << 8) | k;
  endfunction

  // physical slot from the numbering in R2 and the overlap in R4/R12
  function automatic int slot_of(int w, int idx);
    int grp_no = idx / GRP;
    int k = idx % GRP;
    if (grp_no == 1) return w * 2 * GRP + k;
    if (grp_no == 2) return w * 2 * GRP + GRP + k;
    return ((w + 1) % NWIN) * 2 * GRP + k;
  endfunction

  function automatic logic [31:0] model_val(int idx);
    if (idx < GRP) return m_glob[idx];
    return m_win[slot_of(m_cwp, idx)];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_write(int idx, logic [31:0] v);
    if (idx < GRP) m_glob[idx] = v;
    else m_win[slot_of(m_cwp, idx)] = v;
  endtask

  task automatic wr(int idx, logic [31:0] v);
    wr_en_i = 1'b1; wr_idx_i = idx[4:0]; wr_data_i = v;
    @(negedge clk);
    wr_en_i = 1'b0;
    model_write(idx, v);
  endtask

  task automatic rd(string req, int idx);
    rd_a_idx_i = idx[4:0];
    rd_b_idx_i = 5'(NIDX - 1 - idx);
    #1;
    chk(req, rd_a_data_o, model_val(idx));
    chk(req, rd_b_data_o, model_val(NIDX - 1 - idx));
  endtask

  task automatic rd_all(string req);
    for (int i = 0; i < NIDX; i++) rd((i < GRP) ? "R3" : req, i);
  endtask

  task automatic ctl(logic c, logic r, logic s, logic f, string req);
    logic e_ovf = 1'b0;
    logic e_unf = 1'b0;
    call_i = c; ret_i = r; spill_done_i = s; fill_done_i = f;
    @(negedge clk);
    call_i = 1'b0; ret_i = 1'b0; spill_done_i = 1'b0; fill_done_i = 1'b0;
    if (c && !r) begin
      if ((m_cwp + 2) % NWIN == m_swp) e_ovf = 1'b1;
      else m_cwp = (m_cwp + 1) % NWIN;
    end else if (r && !c) begin
      if (m_cwp == m_swp) e_unf = 1'b1;
      else m_cwp = (m_cwp + NWIN - 1) % NWIN;
    end
    if (s && !f) m_swp = (m_swp + 1) % NWIN;
    if (f && !s) m_swp = (m_swp + NWIN - 1) % NWIN;
    chk(req, 32'(cwp_o), 32'(m_cwp));
    chk(req, 32'(swp_o), 32'(m_swp));
    chk(req, 32'(ovf_trap_o), 32'(e_ovf));
    chk(req, 32'(unf_trap_o), 32'(e_unf));
  endtask

  task automatic idle_trap_low(string req);
    @(negedge clk);
    chk(req, 32'(ovf_trap_o), 32'd0);
    chk(req, 32'(unf_trap_o), 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    call_i = 0; ret_i = 0; spill_done_i = 0; fill_done_i = 0;
    wr_en_i = 0; wr_idx_i = 0; wr_data_i = 0; rd_a_idx_i = 0; rd_b_idx_i = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1", 32'(cwp_o), 32'd0);
    chk("R1", 32'(swp_o), 32'd0);
    chk("R1", 32'(ovf_trap_o), 32'd0);
    chk("R1", 32'(unf_trap_o), 32'd0);

    // R3: globals written from window 0
    for (int k = 0; k < GRP; k++) wr(k, 32'h6100_0000 | k);
    // window 0 parameters
    for (int k = 0; k < GRP; k++) wr(GRP + k, 32'h5A00_0000 | k);

    // R2/R4/R5/R7: descend through windows 0..6, overflow at 6
    for (int w = 0; w < NWIN - 1; w++) begin
      for (int k = 0; k < GRP; k++) begin
        wr(2 * GRP + k, loc_val(w, k));
        wr(3 * GRP + k, tmp_val(w, k));
      end
      if (w == 3) wr(5, 32'h6B00_0005);  // R3: global write from a deep window
      rd_all("R4");
      ctl(1'b1, 1'b0, 1'b0, 1'b0, (w == NWIN - 2) ? "R7" : "R5");
      if (w < NWIN - 2) rd_all("R4");  // params now show caller temporaries
    end
    idle_trap_low("R7");

    // R9: spill frees window 0, R5: enter window 7
    ctl(1'b0, 1'b0, 1'b1, 1'b0, "R9");
    ctl(1'b1, 1'b0, 1'b0, 1'b0, "R5");
    for (int k = 0; k < GRP; k++) begin
      wr(2 * GRP + k, loc_val(7, k));
      wr(3 * GRP + k, tmp_val(7, k));  // R12: lands in window 0 params
    end
    rd_all("R12");
    ctl(1'b1, 1'b0, 1'b0, 1'b0, "R7");

    // R6: climb back to window 1, checking private locals on the way
    for (int i = 0; i < NWIN - 2; i++) begin
      ctl(1'b0, 1'b1, 1'b0, 1'b0, "R6");
      rd_all("R4");
    end
    ctl(1'b0, 1'b1, 1'b0, 1'b0, "R8");
    idle_trap_low("R8");
    ctl(1'b0, 1'b0, 1'b0, 1'b1, "R9");
    ctl(1'b0, 1'b1, 1'b0, 1'b0, "R6");
    rd_all("R12");  // window 0 params hold window 7 temporaries
    ctl(1'b0, 1'b1, 1'b0, 1'b0, "R8");

    // R10 and simultaneous spill/fill
    ctl(1'b1, 1'b1, 1'b0, 1'b0, "R10");
    ctl(1'b0, 1'b0, 1'b1, 1'b1, "R9");

    // R11: old value during the write cycle, new value after, and via alias
    wr_en_i = 1'b1; wr_idx_i = 5'(3 * GRP + 2); wr_data_i = 32'hC0DE_0002;
    rd_a_idx_i = 5'(3 * GRP + 2); rd_b_idx_i = 5'(GRP + 2);
    #1;
    chk("R11", rd_a_data_o, model_val(3 * GRP + 2));
    @(negedge clk);
    wr_en_i = 1'b0;
    model_write(3 * GRP + 2, 32'hC0DE_0002);
    rd("R11", 3 * GRP + 2);
    ctl(1'b1, 1'b0, 1'b0, 1'b0, "R5");
    rd("R11", GRP + 2);
    chk("R11", rd_a_data_o, 32'hC0DE_0002);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule